// File: doc/BRIEF.md
# Status Flag Update Unit

This block evaluates one operation per clock cycle on two equal-width operands and keeps the four condition flags (negative, zero, carry, overflow) that later conditional logic reads. The operations are add, subtract and bitwise AND for ordinary data processing. Four more operations change only the flags: a compare by subtraction, a compare by addition, a test by AND and a test by exclusive OR. The bitwise operations take their carry flag from a shifter carry input, because the shifter sits outside this block.

The result and the result-write strobe are combinational from the current inputs. The flag register updates on the next rising clock edge. Compare and test operations always update the flags and never assert the write strobe. Data-processing operations always assert the write strobe, but they update the flags only when the set-flags input is high.

Top module: `flag_update_unit`

## Requirements
- R1: A synchronous active-high `rst` clears `flags_o` to 4'b0000 on the next rising edge, whatever operation is presented in that cycle.
- R2: After an updating operation, the next edge loads `flags_o[3]` (N) with bit WIDTH-1 of that cycle's result, and `flags_o[2]` (Z) with 1 exactly when every result bit was zero.
- R3: For add (`op_i`=0) and compare-add (`op_i`=4), the result is opa+opb modulo 2^WIDTH. C (`flags_o[1]`) is the carry out of the top bit. V (`flags_o[0]`) is 1 when both operands have the same sign and the result sign differs from it.
- R4: For subtract (`op_i`=1) and compare-subtract (`op_i`=3), the result is opa-opb modulo 2^WIDTH. C is 1 exactly when opa >= opb as unsigned values. V is 1 when the operand signs differ and the result sign differs from opa's sign.
- R5: For AND (`op_i`=2), test-AND (`op_i`=5) and test-XOR (`op_i`=6), the result is opa&opb or, for code 6, opa^opb. An update loads C from `shift_carry_i` and leaves V at its previous value.
- R6: Codes 3 to 6 update the flags whatever `set_flags_i` is, and they hold `wr_en_o` low.
- R7: Codes 0 to 2 drive `wr_en_o` high, with `result_o` valid in the same cycle as the inputs.
- R8: Codes 0 to 2 with `set_flags_i` low leave `flags_o` unchanged.
- R9: Code 7 is a no-operation: `result_o` is zero, `wr_en_o` is low and the flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the flags |
| op_i | input | 3 | Operation code (0 add, 1 sub, 2 and, 3 cmp-sub, 4 cmp-add, 5 test-and, 6 test-xor, 7 nop) |
| set_flags_i | input | 1 | Flag-update enable for codes 0 to 2 |
| opa_i | input | WIDTH | First operand |
| opb_i | input | WIDTH | Second operand |
| shift_carry_i | input | 1 | Carry left by the shift stage, used by the bitwise operations |
| result_o | output | WIDTH | Combinational operation result |
| wr_en_o | output | 1 | Result-write strobe |
| flags_o | output | 4 | Registered flags {N,Z,C,V} |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the result write and the flag update: a data-processing add with set-flags high must produce both the write strobe and new flags. The bench issues such operations back to back with flag-only compares and with add operations that have set-flags low. The second pair is reset and an updating operation: the bench presents a compare in the same cycle as `rst`, and the flags must read all zero afterwards. A scoreboard model predicts the result, the strobe and the flags for each cycle, and the flags are compared one edge after the inputs.

// File: rtl/flagu_pkg.sv
package flagu_pkg;
   typedef enum logic [2:0] {
      OP_ADD     = 3'd0,
      OP_SUB     = 3'd1,
      OP_AND     = 3'd2,
      OP_CMP_SUB = 3'd3,
      OP_CMP_ADD = 3'd4,
      OP_TST_AND = 3'd5,
      OP_TST_XOR = 3'd6,
      OP_NOP     = 3'd7
   } flag_op_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } nzcv_t;

   typedef struct packed {
      logic arith;    // adder path selected
      logic sub;      // adder subtracts
      logic log_xor;  // bitwise path is XOR rather than AND
      logic cmp;      // flag-only operation
      logic dp;       // data-processing operation
   } op_ctl_t;
endpackage

// File: rtl/flagu_decode.sv
module flagu_decode
   import flagu_pkg::*;
(
   input  logic [2:0] op_i,
   output op_ctl_t    ctl_o
);
   flag_op_e op;
   assign op = flag_op_e'(op_i);

   always_comb begin
      ctl_o = '0;
      unique case (op)
         OP_ADD:     begin ctl_o.arith = 1'b1; ctl_o.dp = 1'b1; end
         OP_SUB:     begin ctl_o.arith = 1'b1; ctl_o.sub = 1'b1; ctl_o.dp = 1'b1; end
         OP_AND:     begin ctl_o.dp = 1'b1; end
         OP_CMP_SUB: begin ctl_o.arith = 1'b1; ctl_o.sub = 1'b1; ctl_o.cmp = 1'b1; end
         OP_CMP_ADD: begin ctl_o.arith = 1'b1; ctl_o.cmp = 1'b1; end
         OP_TST_AND: begin ctl_o.cmp = 1'b1; end
         OP_TST_XOR: begin ctl_o.cmp = 1'b1; ctl_o.log_xor = 1'b1; end
         default:    ctl_o = '0;
      endcase
   end
endmodule

// File: rtl/flagu_arith.sv
module flagu_arith #(
   parameter int WIDTH          = 32,
   parameter bit CARRY_FROM_SUM = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             sub_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o,
   output logic             ovf_o
);
   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("flagu_arith: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] b_eff;
   assign b_eff = sub_i ? ~b_i : b_i;

   if (CARRY_FROM_SUM) begin : g_wide
      // One adder one bit wider than the operands; overflow from the signs.
      logic [WIDTH:0] ext;
      assign ext    = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
      assign sum_o  = ext[MSB:0];
      assign cout_o = ext[WIDTH];
      assign ovf_o  = (a_i[MSB] == b_eff[MSB]) && (ext[MSB] != a_i[MSB]);
   end else begin : g_msb
      // Lower bits added separately; the carries into and out of the top bit give V.
      logic [MSB:0] low;
      logic         c_in_msb;
      assign low      = {1'b0, a_i[MSB-1:0]} + {1'b0, b_eff[MSB-1:0]} + {{MSB{1'b0}}, sub_i};
      assign c_in_msb = low[MSB];
      assign sum_o    = {a_i[MSB] ^ b_eff[MSB] ^ c_in_msb, low[MSB-1:0]};
      assign cout_o   = (a_i[MSB] & b_eff[MSB]) | (c_in_msb & (a_i[MSB] ^ b_eff[MSB]));
      assign ovf_o    = c_in_msb ^ cout_o;
   end
endmodule

// File: rtl/flagu_regs.sv
module flagu_regs
   import flagu_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  upd_i,
   input  logic  keep_v_i,
   input  nzcv_t nxt_i,
   output nzcv_t flags_o
);
   nzcv_t flags_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         flags_q <= '0;
      end else if (upd_i) begin
         flags_q.n <= nxt_i.n;
         flags_q.z <= nxt_i.z;
         flags_q.c <= nxt_i.c;
         flags_q.v <= keep_v_i ? flags_q.v : nxt_i.v;
      end
   end

   assign flags_o = flags_q;

   assert_reset_clear_R1: assert property (@(posedge clk) rst |=> (flags_o == '0))
      else $error("R1: flags not cleared by reset");

   assert_v_kept_R5: assert property (@(posedge clk) disable iff (rst)
      (upd_i && keep_v_i) |=> (flags_o.v == $past(flags_o.v)))
      else $error("R5: V changed on bitwise update");

   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !upd_i |=> $stable(flags_o))
      else $error("R8: flags changed without update");
endmodule

// File: rtl/flag_update_unit.sv
module flag_update_unit
   import flagu_pkg::*;
#(
   parameter int WIDTH          = 32,
   parameter bit CARRY_FROM_SUM = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [2:0]       op_i,
   input  logic             set_flags_i,
   input  logic [WIDTH-1:0] opa_i,
   input  logic [WIDTH-1:0] opb_i,
   input  logic             shift_carry_i,
   output logic [WIDTH-1:0] result_o,
   output logic             wr_en_o,
   output logic [3:0]       flags_o
);
   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("flag_update_unit: WIDTH must be at least 2");
   end

   op_ctl_t          ctl;
   logic [WIDTH-1:0] sum;
   logic             cout;
   logic             ovf;
   logic [WIDTH-1:0] logic_res;
   logic             upd;
   nzcv_t            nxt;
   nzcv_t            flags_q;

   flagu_decode u_decode (
      .op_i  (op_i),
      .ctl_o (ctl)
   );

   flagu_arith #(.WIDTH(WIDTH), .CARRY_FROM_SUM(CARRY_FROM_SUM)) u_arith (
      .a_i    (opa_i),
      .b_i    (opb_i),
      .sub_i  (ctl.sub),
      .sum_o  (sum),
      .cout_o (cout),
      .ovf_o  (ovf)
   );

   assign logic_res = ctl.log_xor ? (opa_i ^ opb_i) : (opa_i & opb_i);

   always_comb begin
      if (!(ctl.cmp || ctl.dp)) result_o = '0;
      else if (ctl.arith)       result_o = sum;
      else                      result_o = logic_res;
   end

   assign wr_en_o = ctl.dp;
   assign upd     = ctl.cmp || (ctl.dp && set_flags_i);

   assign nxt.n = result_o[MSB];
   assign nxt.z = (result_o == '0);
   assign nxt.c = ctl.arith ? cout : shift_carry_i;
   assign nxt.v = ovf;

   flagu_regs u_regs (
      .clk      (clk),
      .rst      (rst),
      .upd_i    (upd),
      .keep_v_i (!ctl.arith),
      .nxt_i    (nxt),
      .flags_o  (flags_q)
   );

   assign flags_o = flags_q;

   assert_cmp_no_write_R6: assert property (@(posedge clk) disable iff (rst)
      (op_i inside {3'd3, 3'd4, 3'd5, 3'd6}) |-> !wr_en_o)
      else $error("R6: write strobe on compare or test");

   assert_dp_write_R7: assert property (@(posedge clk) disable iff (rst)
      (op_i <= 3'd2) |-> wr_en_o)
      else $error("R7: missing write strobe");

   assert_sub_carry_R4: assert property (@(posedge clk) disable iff (rst)
      (op_i == 3'd1 || op_i == 3'd3) |-> (cout == (opa_i >= opb_i)))
      else $error("R4: subtract carry is not the inverted borrow");

   assert_n_z_track_R2: assert property (@(posedge clk) disable iff (rst)
      ((op_i inside {3'd3, 3'd4, 3'd5, 3'd6}) || (op_i <= 3'd2 && set_flags_i))
      |=> (flags_o[3] == $past(result_o[MSB]) && flags_o[2] == ($past(result_o) == '0)))
      else $error("R2: N or Z does not follow the result");

   assert_nop_quiet_R9: assert property (@(posedge clk) disable iff (rst)
      (op_i == 3'd7) |-> (result_o == '0 && !wr_en_o))
      else $error("R9: no-operation produced output");
endmodule

// File: tb/test_flag_update_unit.sv
module test_flag_update_unit;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int W = 32;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [2:0]    op_i = 3'd7;
   logic          set_flags_i = 1'b0;
   logic [W-1:0]  opa_i = '0;
   logic [W-1:0]  opb_i = '0;
   logic          shift_carry_i = 1'b0;
   logic [W-1:0]  result_o;
   logic          wr_en_o;
   logic [3:0]    flags_o;

   always #2.5 clk = ~clk;

   flag_update_unit #(.WIDTH(W)) i_flag_update_unit (
      .clk           (clk),
      .rst           (rst),
      .op_i          (op_i),
      .set_flags_i   (set_flags_i),
      .opa_i         (opa_i),
      .opb_i         (opb_i),
      .shift_carry_i (shift_carry_i),
      .result_o      (result_o),
      .wr_en_o       (wr_en_o),
      .flags_o       (flags_o)
   );

   typedef struct {
      logic [W-1:0] res;
      logic         wr;
      logic [3:0]   fl;
      string        tag;
   } item_t;

   item_t      sb[$];
   int         checks = 0;
   int         fails = 0;
   logic [3:0] mflags = 4'b0000;

   task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // Driver: applies one operation per cycle and pushes its predicted outcome.
   task automatic drive(logic r, logic [2:0] op, logic sf, logic [W-1:0] a,
                        logic [W-1:0] b, logic sc, string tag);
      item_t        it;
      logic [W:0]   wide;
      logic [W-1:0] res;
      logic         c;
      logic         v;
      logic         upd;
      @(negedge clk);
      rst = r; op_i = op; set_flags_i = sf; opa_i = a; opb_i = b; shift_carry_i = sc;
      c = 1'b0; v = mflags[0];
      case (op)
         3'd0, 3'd4: begin
            wide = {1'b0, a} + {1'b0, b};
            res  = wide[W-1:0];
            c    = wide[W];
            v    = (a[W-1] == b[W-1]) && (res[W-1] != a[W-1]);
         end
         3'd1, 3'd3: begin
            res = a - b;
            c   = (a >= b);
            v   = (a[W-1] != b[W-1]) && (res[W-1] != a[W-1]);
         end
         3'd2, 3'd5: begin res = a & b; c = sc; end
         3'd6:       begin res = a ^ b; c = sc; end
         default:    res = '0;
      endcase
      upd = (op >= 3'd3 && op <= 3'd6) || (op <= 3'd2 && sf);
      if (r)        mflags = 4'b0000;
      else if (upd) mflags = {res[W-1], (res == '0), c, v};
      it.res = res;
      it.wr  = (op <= 3'd2);
      it.fl  = mflags;
      it.tag = tag;
      sb.push_back(it);
   endtask

   // Monitor: one edge after the inputs, compare outputs to the oldest item.
   initial begin
      forever begin
         item_t it;
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            it = sb.pop_front();
            check(it.tag, "result", result_o, it.res);
            check(it.tag, "wr_en", {{(W-1){1'b0}}, wr_en_o}, {{(W-1){1'b0}}, it.wr});
            check(it.tag, "flags", {{(W-4){1'b0}}, flags_o}, {{(W-4){1'b0}}, it.fl});
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired, all requirements");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      drive(1'b1, 3'd7, 1'b0, 32'h0, 32'h0, 1'b0, "R1 reset");
      drive(1'b1, 3'd7, 1'b0, 32'h0, 32'h0, 1'b0, "R1 reset");
      // R3 add carry-out and zero, R2
      drive(1'b0, 3'd0, 1'b1, 32'hFFFF_FFFF, 32'h1, 1'b0, "R3 R2 add wrap");
      // R3 signed overflow to negative
      drive(1'b0, 3'd0, 1'b1, 32'h7FFF_FFFF, 32'h1, 1'b0, "R3 add ovf");
      // R8 add with set-flags low: flags held
      drive(1'b0, 3'd0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R8 R7 add no sf");
      drive(1'b0, 3'd1, 1'b0, 32'h5, 32'h5, 1'b0, "R8 sub no sf");
      drive(1'b0, 3'd2, 1'b0, 32'h0, 32'h0, 1'b1, "R8 and no sf");
      // R4 subtract corners
      drive(1'b0, 3'd1, 1'b1, 32'h5, 32'h5, 1'b0, "R4 sub equal");
      drive(1'b0, 3'd1, 1'b1, 32'h3, 32'h5, 1'b0, "R4 sub borrow");
      drive(1'b0, 3'd1, 1'b1, 32'h8000_0000, 32'h1, 1'b0, "R4 sub ovf");
      // R5 AND with shifter carry, V kept at 1 from the previous step
      drive(1'b0, 3'd2, 1'b1, 32'hF0F0_F0F0, 32'h8F0F_0F0F, 1'b1, "R5 and sc1");
      drive(1'b0, 3'd2, 1'b1, 32'h0000_FFFF, 32'h1234_0000, 1'b0, "R5 and zero");
      // R6 compare and test with set-flags low still update, no write
      drive(1'b0, 3'd3, 1'b0, 32'h10, 32'h20, 1'b1, "R6 R4 cmp-sub");
      drive(1'b0, 3'd4, 1'b0, 32'h8000_0000, 32'h8000_0000, 1'b0, "R6 R3 cmp-add");
      drive(1'b0, 3'd5, 1'b0, 32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R6 R5 test-and");
      drive(1'b0, 3'd6, 1'b1, 32'hDEAD_BEEF, 32'h5EAD_BEEF, 1'b0, "R6 R5 test-xor");
      // R9 no-operation ignores operands
      drive(1'b0, 3'd7, 1'b1, 32'hFFFF_FFFF, 32'h1, 1'b1, "R9 nop");
      // R7 write and flag update in the same cycle
      drive(1'b0, 3'd1, 1'b1, 32'h1, 32'h2, 1'b1, "R7 R4 sub sf");
      drive(1'b0, 3'd0, 1'b1, 32'h8000_0000, 32'h8000_0000, 1'b0, "R7 R3 add sf");
      // R1 reset together with a compare
      drive(1'b1, 3'd3, 1'b0, 32'h1, 32'h2, 1'b0, "R1 reset with cmp");
      drive(1'b0, 3'd7, 1'b0, 32'h0, 32'h0, 1'b0, "R9 idle");
      while (sb.size() > 0) @(posedge clk);
      @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule